// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation entries from memory. A walk starts in a per-context slot of a context table. It then goes down through as many as three levels of tables, and it stops as soon as it finds a page entry. A page entry found at the first level maps 16 MB, one found at the second level maps 256 KB, and one found at the third level maps 4 KB. Every fetched word carries a two-bit type code. That code tells the walker to descend, to finish, or to stop with a fault that reports the level and a fault kind.

The walker accepts one request at a time and fetches entries through a memory port that has a single transaction in flight. Each word read or word write is held until the memory acknowledges it. When a walk ends on a page entry whose referenced flag is clear, or when a write finds the modified flag clear, the walker sets the needed flags and writes the entry back to the address it came from. Three small registers, written through a configuration port, hold the translation enable, the context table root and the current context number. While translation is off, requests pass straight through with no table traffic.

Top module: `xlat_walker`

## Requirements
- R1: With bit 0 of the control register (cfg_sel 0) clear, an accepted request finishes one cycle later with rsp_pa equal to the zero-extended virtual address, rsp_all_rights 1, rsp_fault 0, and no memory transaction.
- R2: With translation on, the first fetch reads address (root << 4) + (context << 2). The root is written with cfg_sel 1 and the context number with cfg_sel 2.
- R3: The type of a fetched entry is in bits 1:0: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved. A descriptor makes the next fetch read ({entry[31:2], 2'b00} << 4) plus an index. The index is VA[31:24]*4 for level 1, VA[23:18]*4 for level 2 and VA[17:12]*4 for level 3.
- R4: A page entry at level 1 gives rsp_pa = (entry[31:8] << 12) + VA[23:0].
- R5: A page entry at level 2 gives rsp_pa = (entry[31:8] << 12) + VA[17:0].
- R6: A page entry at level 3 gives rsp_pa = (entry[31:8] << 12) + VA[11:0].
- R7: An invalid entry ends the walk with rsp_fault 1 and rsp_fcode = (level << 8) | (1 << 2). Level 0 is the context slot.
- R8: A reserved entry, a page entry in the context slot, or a descriptor at level 3 ends the walk with rsp_fault 1 and rsp_fcode = (level << 8) | (4 << 2).
- R9: The referenced flag is bit 5 and the modified flag is bit 6. When the final page entry has referenced clear, or the access is a write with modified clear, the walker writes the entry back to the same address with referenced set, and with modified also set on a write. Otherwise it makes no write.
- R10: After reset req_ready is 1 and done and mem_req are 0. A request is taken only while req_ready is 1, and req_ready falls after acceptance. done is high for exactly one cycle. mem_req, mem_we and mem_addr stay steady until mem_ack.
- R11: On success rsp_pte is the final entry with the flags updated as in R9, and rsp_fcode is 0. On a fault rsp_pte is the offending entry and rsp_pa is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 root, 2 context |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fcode | output | 10 | Fault level in bits 9:8, fault kind in bits 4:2 |
| rsp_pa | output | 36 | Physical address |
| rsp_pte | output | 32 | Final entry (updated) or offending entry |
| rsp_all_rights | output | 1 | Translation off, every access right granted |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Pending transaction is a write-back |
| mem_addr | output | 36 | Word address of the entry |
| mem_wdata | output | 32 | Entry value to write back |
| mem_ack | input | 1 | Memory completes the pending transaction |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The assertions check the rules that must hold on every cycle. These are the single-cycle done pulse, that no request is taken while busy, that a pending memory transaction stays steady until it is acknowledged, that a write-back starts at the address just read and always carries the referenced flag, that translation-off requests cause no memory traffic, and the bit layout of fault codes. Some behaviour only the scripted walks can show: the actual fetch addresses and index arithmetic at each level, the physical address for each page size, which level and kind a given table defect reports, and whether a write-back happens at all for each combination of flags and access type. The bench checks these against its own model of the tables.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 36;
  localparam int ENT_W   = 32;
  localparam int LVL_W   = 2;
  localparam int FC_W    = 10;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam int PPN_LSB = 8;
  localparam int PAGE_SH = 12;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_BADTYPE = 3'd4;

  localparam logic [1:0] CFG_CTRL = 2'd0;
  localparam logic [1:0] CFG_ROOT = 2'd1;
  localparam logic [1:0] CFG_CTX  = 2'd2;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_TABLE   = 2'd1,
    ET_PAGE    = 2'd2,
    ET_RESV    = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    ACT_DESCEND,
    ACT_LEAF,
    ACT_FAULT
  } step_act_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_WBACK,
    S_FIN
  } walk_state_e;
endpackage

// File: rtl/xlat_cfg_regs.sv
module xlat_cfg_regs
  import xlat_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ENT_W-1:0]  cfg_wdata,
  output logic              cfg_en,
  output logic [ENT_W-1:0]  cfg_root,
  output logic [CTX_W-1:0]  cfg_ctx
);
  logic             en_ld, root_ld, ctx_ld;
  logic             unused_cfg_bits;

  assign en_ld   = cfg_we && (cfg_sel == CFG_CTRL);
  assign root_ld = cfg_we && (cfg_sel == CFG_ROOT);
  assign ctx_ld  = cfg_we && (cfg_sel == CFG_CTX);
  assign unused_cfg_bits = ^cfg_wdata[ENT_W-1:CTX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en   <= 1'b0;
      cfg_root <= '0;
      cfg_ctx  <= '0;
    end else begin
      if (en_ld)   cfg_en   <= cfg_wdata[0];
      if (root_ld) cfg_root <= cfg_wdata;
      if (ctx_ld)  cfg_ctx  <= cfg_wdata[CTX_W-1:0];
    end
  end
endmodule

// File: rtl/xlat_step.sv
module xlat_step
  import xlat_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  va,
  input  logic             wr,
  output step_act_e        act,
  output logic [PA_W-1:0]  nxt_addr,
  output logic [FC_W-1:0]  fcode,
  output logic [PA_W-1:0]  leaf_pa,
  output logic [ENT_W-1:0] upd_entry,
  output logic             need_wb
);
  ent_type_e   etype;
  logic [9:0]  idx;
  logic [23:0] offs;
  logic [2:0]  ftype;
  logic [PA_W-1:0] tbl_base, page_base;

  assign etype     = ent_type_e'(entry[1:0]);
  assign tbl_base  = {entry[ENT_W-1:2], 6'b0};
  assign page_base = {entry[ENT_W-1:PPN_LSB], {PAGE_SH{1'b0}}};

  // index into the table one level below the current one
  always_comb begin
    case (lvl)
      2'd0:    idx = {va[31:24], 2'b00};
      2'd1:    idx = {2'b00, va[23:18], 2'b00};
      default: idx = {2'b00, va[17:12], 2'b00};
    endcase
  end

  // page offset depends on where the page entry was found
  always_comb begin
    case (lvl)
      2'd1:    offs = va[23:0];
      2'd2:    offs = {6'b0, va[17:0]};
      default: offs = {12'b0, va[11:0]};
    endcase
  end

  assign nxt_addr = tbl_base + PA_W'(idx);
  assign leaf_pa  = page_base + PA_W'(offs);

  always_comb begin
    act   = ACT_FAULT;
    ftype = FT_BADTYPE;
    case (etype)
      ET_INVALID: ftype = FT_INVALID;
      ET_TABLE:   if (lvl != 2'd3) act = ACT_DESCEND;
      ET_PAGE:    if (lvl != 2'd0) act = ACT_LEAF;
      default:    ftype = FT_BADTYPE;
    endcase
  end

  assign fcode = {lvl, 3'b000, ftype, 2'b00};

  always_comb begin
    upd_entry = entry;
    upd_entry[REF_BIT] = 1'b1;
    if (wr) upd_entry[MOD_BIT] = 1'b1;
  end

  assign need_wb = !entry[REF_BIT] || (wr && !entry[MOD_BIT]);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  input  logic              req_write,
  output logic              done,
  output logic              rsp_fault,
  output logic [9:0]        rsp_fcode,
  output logic [35:0]       rsp_pa,
  output logic [31:0]       rsp_pte,
  output logic              rsp_all_rights,
  output logic              mem_req,
  output logic              mem_we,
  output logic [35:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  logic             cfg_en;
  logic [ENT_W-1:0] cfg_root;
  logic [CTX_W-1:0] cfg_ctx;

  walk_state_e      state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [VA_W-1:0]  va_q, va_d;
  logic             wr_q, wr_d;
  logic [PA_W-1:0]  addr_q, addr_d;
  logic [ENT_W-1:0] wdat_q, wdat_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic [ENT_W-1:0] pte_q, pte_d;
  logic             flt_q, flt_d;
  logic [FC_W-1:0]  fc_q, fc_d;
  logic             all_q, all_d;
  logic             res_en;

  step_act_e        st_act;
  logic [PA_W-1:0]  st_nxt, st_pa;
  logic [FC_W-1:0]  st_fc;
  logic [ENT_W-1:0] st_upd;
  logic             st_wb;

  xlat_cfg_regs #(.CTX_W(CTX_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .cfg_en   (cfg_en),
    .cfg_root (cfg_root),
    .cfg_ctx  (cfg_ctx)
  );

  xlat_step u_step (
    .entry    (mem_rdata),
    .lvl      (lvl_q),
    .va       (va_q),
    .wr       (wr_q),
    .act      (st_act),
    .nxt_addr (st_nxt),
    .fcode    (st_fc),
    .leaf_pa  (st_pa),
    .upd_entry(st_upd),
    .need_wb  (st_wb)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    va_d    = va_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    pa_d    = pa_q;
    pte_d   = pte_q;
    flt_d   = flt_q;
    fc_d    = fc_q;
    all_d   = all_q;
    res_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          va_d = req_va;
          wr_d = req_write;
          if (!cfg_en) begin
            res_en  = 1'b1;
            pa_d    = PA_W'(req_va);
            pte_d   = '0;
            flt_d   = 1'b0;
            fc_d    = '0;
            all_d   = 1'b1;
            state_d = S_FIN;
          end else begin
            addr_d  = {cfg_root, 4'b0} + PA_W'({cfg_ctx, 2'b00});
            lvl_d   = '0;
            state_d = S_FETCH;
          end
        end
      end
      S_FETCH: begin
        if (mem_ack) begin
          case (st_act)
            ACT_DESCEND: begin
              addr_d = st_nxt;
              lvl_d  = lvl_q + 1'b1;
            end
            ACT_LEAF: begin
              res_en  = 1'b1;
              pa_d    = st_pa;
              pte_d   = st_upd;
              flt_d   = 1'b0;
              fc_d    = '0;
              all_d   = 1'b0;
              wdat_d  = st_upd;
              state_d = st_wb ? S_WBACK : S_FIN;
            end
            default: begin
              res_en  = 1'b1;
              pa_d    = '0;
              pte_d   = mem_rdata;
              flt_d   = 1'b1;
              fc_d    = st_fc;
              all_d   = 1'b0;
              state_d = S_FIN;
            end
          endcase
        end
      end
      S_WBACK: if (mem_ack) state_d = S_FIN;
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      pa_q    <= '0;
      pte_q   <= '0;
      flt_q   <= 1'b0;
      fc_q    <= '0;
      all_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      va_q    <= va_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      if (res_en) begin
        pa_q  <= pa_d;
        pte_q <= pte_d;
        flt_q <= flt_d;
        fc_q  <= fc_d;
        all_q <= all_d;
      end
    end
  end

  assign req_ready      = (state_q == S_IDLE);
  assign done           = (state_q == S_FIN);
  assign mem_req        = (state_q == S_FETCH) || (state_q == S_WBACK);
  assign mem_we         = (state_q == S_WBACK);
  assign mem_addr       = addr_q;
  assign mem_wdata      = wdat_q;
  assign rsp_pa         = pa_q;
  assign rsp_pte        = pte_q;
  assign rsp_fault      = flt_q;
  assign rsp_fcode      = fc_q;
  assign rsp_all_rights = all_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        rsp_fault,
  input logic [9:0]  rsp_fcode,
  input logic        mem_req,
  input logic        mem_we,
  input logic [35:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        cfg_en
);
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_bypass_no_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_en) |=> (done && !mem_req));

  p_fault_layout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_fault) |-> ((rsp_fcode[4:2] == 3'd1 || rsp_fcode[4:2] == 3'd4)
                             && rsp_fcode[7:5] == 3'd0 && rsp_fcode[1:0] == 2'd0));

  p_ok_code_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rsp_fault) |-> (rsp_fcode == 10'd0));

  p_wb_same_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $stable(mem_addr));

  p_wb_ref_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]);
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .rsp_fault(rsp_fault),
  .rsp_fcode(rsp_fcode),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack),
  .cfg_en   (cfg_en)
);

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_va;
  logic        req_write;
  logic        done, rsp_fault, rsp_all_rights;
  logic [9:0]  rsp_fcode;
  logic [35:0] rsp_pa;
  logic [31:0] rsp_pte;
  logic        mem_req, mem_we, mem_ack;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  xlat_walker uut (.*);

  typedef struct {
    logic [35:0] pa;
    logic [31:0] pte;
    logic        fault;
    logic [9:0]  fcode;
    logic        all;
    int          nrd;
    int          nwr;
    logic [35:0] wa;
    logic [31:0] wd;
    string       req;
  } item_t;

  item_t       exp_q[$];
  logic [31:0] tbl [logic [35:0]];
  int          total = 0, bad = 0;
  int          nrd = 0, nwr = 0, lat = 1;
  logic [35:0] last_wa;
  logic [31:0] last_wd;
  logic        en_s = 1'b0;
  logic [31:0] root_s = '0;
  logic [7:0]  ctx_s = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [35:0] a);
    return tbl.exists(a) ? tbl[a] : 32'h0;
  endfunction

  function automatic logic [31:0] desc(input logic [35:0] a);
    return a[35:4] | 32'h1;
  endfunction

  // expected result, built from the requirements
  function automatic item_t model(input logic [31:0] va, input bit wr);
    item_t it;
    logic [35:0] a;
    logic [31:0] e;
    logic [35:0] off;
    it.pa = '0; it.pte = '0; it.fault = 0; it.fcode = '0; it.all = 0;
    it.nrd = 0; it.nwr = 0; it.wa = '0; it.wd = '0; it.req = "";
    if (!en_s) begin
      it.pa = {4'h0, va};
      it.all = 1;
      return it;
    end
    a = {root_s, 4'h0} + {26'h0, ctx_s, 2'b00};
    for (int l = 0; l < 4; l++) begin
      e = rdm(a);
      it.nrd++;
      if (e[1:0] == 2'd0 || e[1:0] == 2'd3 || (e[1:0] == 2'd1 && l == 3) ||
          (e[1:0] == 2'd2 && l == 0)) begin
        it.fault = 1;
        it.pte   = e;
        it.fcode = (10'(l) << 8) | ((e[1:0] == 2'd0) ? 10'h004 : 10'h010);
        return it;
      end
      if (e[1:0] == 2'd1) begin
        if (l == 0)      a = {e[31:2], 6'b0} + {26'h0, va[31:24], 2'b00};
        else if (l == 1) a = {e[31:2], 6'b0} + {28'h0, va[23:18], 2'b00};
        else             a = {e[31:2], 6'b0} + {28'h0, va[17:12], 2'b00};
      end else begin
        off = (l == 1) ? {12'h0, va[23:0]} : (l == 2) ? {18'h0, va[17:0]} : {24'h0, va[11:0]};
        it.pa  = {e[31:8], 12'h0} + off;
        it.pte = e | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (!e[5] || (wr && !e[6])) begin
          it.nwr = 1; it.wa = a; it.wd = it.pte;
        end
        return it;
      end
    end
    return it;
  endfunction

  // memory responder
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (rst_n && mem_req) begin
        if (lat == 0) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            tbl[mem_addr] = mem_wdata;
            nwr++; last_wa = mem_addr; last_wd = mem_wdata;
          end else begin
            mem_rdata = rdm(mem_addr);
            nrd++;
          end
          lat = (nrd + nwr) % 3;
        end else lat--;
      end
    end
  end

  // monitor: pop and compare at every result strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
        else begin
          item_t x;
          x = exp_q.pop_front();
          chk(rsp_pa == x.pa, x.req, "pa", rsp_pa, x.pa);
          chk(rsp_pte == x.pte, x.req, "pte R11", rsp_pte, x.pte);
          chk(rsp_fault == x.fault, x.req, "fault", rsp_fault, x.fault);
          chk(rsp_fcode == x.fcode, x.req, "fcode", rsp_fcode, x.fcode);
          chk(rsp_all_rights == x.all, x.req, "all_rights", rsp_all_rights, x.all);
          chk(nrd == x.nrd, x.req, "fetch count R2 R3", nrd, x.nrd);
          chk(nwr == x.nwr, x.req, "writeback count R9", nwr, x.nwr);
          if (x.nwr != 0) begin
            chk(last_wa == x.wa, x.req, "writeback addr R9", last_wa, x.wa);
            chk(last_wd == x.wd, x.req, "writeback data R9", last_wd, x.wd);
          end
        end
        nrd = 0; nwr = 0;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) en_s = d[0];
    else if (sel == 2'd1) root_s = d;
    else if (sel == 2'd2) ctx_s = d[7:0];
  endtask

  task automatic run(input logic [31:0] va, input bit wr, input string req);
    item_t it;
    it = model(va, wr);
    it.req = req;
    exp_q.push_back(it);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready after accept", req_ready, 0);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_va = '0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    chk(mem_req == 1'b0, "R10", "reset mem_req", mem_req, 0);

    // tables: context table at 0x01000000, level-1 at 0x02000000
    tbl[36'h0_0100_0014] = desc(36'h0_0200_0000);
    tbl[36'h0_0200_000C] = 32'h0450_0012;
    tbl[36'h0_0200_0028] = desc(36'h0_0300_0000);
    tbl[36'h0_0300_009C] = 32'h1234_0022;
    tbl[36'h0_0300_0040] = desc(36'h0_0400_0000);
    tbl[36'h0_0400_0014] = 32'hDEAD_BE62;
    tbl[36'h0_0200_002C] = 32'h0000_0003;
    tbl[36'h0_0300_0044] = desc(36'h0_0400_0100);
    tbl[36'h0_0400_011C] = desc(36'h0_0500_0000);
    tbl[36'h0_0100_0018] = 32'h0000_0002;

    run(32'h1234_5678, 1'b0, "R1 bypass");
    cfg_write(2'd1, 32'h0010_0000);
    cfg_write(2'd2, 32'h0000_0005);
    cfg_write(2'd0, 32'h0000_0001);
    run(32'h0312_3456, 1'b0, "R2 R4 R9 L1 page ref clear");
    run(32'h0312_3456, 1'b0, "R4 R9 L1 page no writeback");
    run(32'h0A9C_1234, 1'b1, "R3 R5 R9 L2 page write");
    run(32'h0A40_5ABC, 1'b1, "R3 R6 R9 L3 page flags set");
    run(32'h0A40_5FFF, 1'b0, "R6 L3 page read");
    run(32'h0A40_6000, 1'b0, "R7 invalid at L3");
    run(32'h0A80_0000, 1'b0, "R7 invalid at L2");
    run(32'h0B00_0000, 1'b0, "R8 reserved at L1");
    run(32'h0A44_7000, 1'b0, "R8 descriptor at L3");
    cfg_write(2'd2, 32'h0000_0006);
    run(32'h0000_1000, 1'b0, "R8 page in context slot");
    cfg_write(2'd2, 32'h0000_0007);
    run(32'h0000_2000, 1'b1, "R7 invalid context slot");
    cfg_write(2'd0, 32'h0000_0000);
    run(32'hFFFF_FFFF, 1'b1, "R1 bypass high address");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule